// File: doc/BRIEF.md
# Event Counter Bank for a Cache Slice

This block holds eight independent 64-bit event counters that sit beside a cache slice. Each cycle the slice presents a vector of single-cycle event pulses. Every counter has its own 8-bit select code that picks one of those pulses, and the counter adds one on each cycle the picked pulse is high. Software reaches the bank through a plain register port: an address, a write strobe, 64-bit write data and a registered 64-bit read return.

The select code also serves as the run control. A counter with code zero is idle and keeps its value. A counter with any nonzero code is live. The usual software sequence is: clear the data register, write a nonzero code to start, write code zero to stop, then read the count. Codes 0x01 through 0x24 map to event lines 0 through 35. Larger codes are stored and read back, but they match no line.

Top module: `evc_bank`

## Requirements
- R1: After reset every counter value and every select code reads as zero.
- R2: The data register of counter n is at byte address 0x000 + 8*n. A write stores all 64 bits, and a read returns the current count.
- R3: The control register of counter n is at byte address 0x100 + 8*n. A write keeps only bits 7:0 as the select code. A read returns the code in bits 7:0 and zero in bits 63:8.
- R4: With a select code k in the range 0x01 to 0x24, the counter adds one on each clock edge at which evt_i[k-1] is high.
- R5: With select code 0x00 the counter does not change, whatever the event lines do.
- R6: A select code above 0x24 counts nothing. It still reads back exactly as written.
- R7: A data register write on the same edge as a qualifying event loads the written value, and that event's increment is lost.
- R8: A counter at all ones that takes an increment wraps to zero.
- R9: Read data appears on rdata_o on the clock edge after the address is presented. It shows the register state before any write made at that same edge.
- R10: Some addresses are unmapped: those with bits 2:0 nonzero, those with a counter index (bits 7:3) of 8 or more, and those with bits 11:8 other than 0x0 or 0x1. A read of an unmapped address returns zero, and a write to one changes nothing.
- R11: A write, a select code or an event aimed at one counter leaves every other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Registered read data |
| evt_i | input | 36 | Event pulses; bit k-1 is event code k |

## Verification
The bench aims at the edges of the code space. It checks code 0x24 (the top line), code 0x00 and a code above 0x24. A decoder that is off by one would count the wrong line, and a design that ignored the idle rule would keep counting after a stop. It holds an event high through a data write to show that the write wins. A design with the wrong priority would read back the written value plus one. It also checks a wrap from all ones, reads taken at the same edge as a write (a read path without a register would show the new value early), and writes to misaligned or out-of-range addresses. Those writes must not alias onto counters 0 or 1.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned SEL_W  = 8;
  localparam logic [3:0]  DATA_REGION = 4'h0;
  localparam logic [3:0]  CTRL_REGION = 4'h1;

  typedef struct packed {
    logic       ok;
    logic       is_data;
    logic       is_ctrl;
    logic [4:0] slot;
  } reg_dec_t;

  // Split a byte address into region, slot and validity.
  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned n_slots);
    reg_dec_t d;
    d         = '0;
    d.slot    = a[7:3];
    d.is_data = (a[11:8] == DATA_REGION);
    d.is_ctrl = (a[11:8] == CTRL_REGION);
    d.ok      = (a[2:0] == 3'b000) && (32'(a[7:3]) < n_slots) &&
                (d.is_data || d.is_ctrl);
    return d;
  endfunction

endpackage

// File: rtl/evc_decode.sv
module evc_decode
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  output logic [NUM_CNT-1:0] wr_data_o,
  output logic [NUM_CNT-1:0] wr_ctrl_o,
  output logic               rd_ok_o,
  output logic               rd_ctrl_o,
  output logic [4:0]         rd_slot_o
);

  reg_dec_t dec;

  always_comb begin
    dec       = decode_addr(addr_i, NUM_CNT);
    rd_ok_o   = dec.ok;
    rd_ctrl_o = dec.is_ctrl;
    rd_slot_o = dec.slot;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_strobe
    assign wr_data_o[g] = we_i && dec.ok && dec.is_data && (dec.slot == 5'(g));
    assign wr_ctrl_o[g] = we_i && dec.ok && dec.is_ctrl && (dec.slot == 5'(g));
  end

  always_comb begin
    assert_single_strobe_R11: assert ($onehot0({wr_data_o, wr_ctrl_o}));
  end

endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_EVT = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_data_i,
  input  logic               wr_ctrl_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [SEL_W-1:0]   sel_o
);

  localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(NUM_EVT);

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             evt_hit;

  // Code k picks line k-1; zero and codes past the last line pick nothing.
  function automatic logic pick_event(input logic [SEL_W-1:0] code,
                                      input logic [NUM_EVT-1:0] lines);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < int'(NUM_EVT); k++) begin
      if (code == SEL_W'(k + 1)) hit = lines[k];
    end
    return hit;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign evt_hit = pick_event(sel_q, evt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_data_i)    cnt_q <= wdata_i;
      else if (evt_hit) cnt_q <= bump(cnt_q);
      if (wr_ctrl_i)    sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data_i && evt_hit) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data_i && sel_q == '0) |=> $stable(cnt_q));
  assert_high_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data_i && sel_q > MAX_CODE) |=> $stable(cnt_q));
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_i |=> cnt_q == $past(wdata_i));
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data_i && evt_hit && (&cnt_q)) |=> cnt_q == '0);
  assert_code_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_i |=> sel_q == $past(wdata_i[SEL_W-1:0]));

endmodule

// File: rtl/evc_rdmux.sv
module evc_rdmux
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_ok_i,
  input  logic             rd_ctrl_i,
  input  logic [4:0]       rd_slot_i,
  input  logic [CNT_W-1:0] cnt_i [NUM_CNT],
  input  logic [SEL_W-1:0] sel_i [NUM_CNT],
  output logic [CNT_W-1:0] rdata_o
);

  logic [CNT_W-1:0] rd_next;
  logic [CNT_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    if (rd_ok_i) begin
      for (int k = 0; k < int'(NUM_CNT); k++) begin
        if (rd_slot_i == 5'(k)) begin
          rd_next = rd_ctrl_i ? {{(CNT_W-SEL_W){1'b0}}, sel_i[k]} : cnt_i[k];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok_i |=> rdata_o == '0);
  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok_i && !rd_ctrl_i && rd_slot_i == 5'd0) |=> rdata_o == $past(cnt_i[0]));

endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned NUM_EVT = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [NUM_EVT-1:0] evt_i
);

  logic [NUM_CNT-1:0] wr_data;
  logic [NUM_CNT-1:0] wr_ctrl;
  logic               rd_ok;
  logic               rd_ctrl;
  logic [4:0]         rd_slot;
  logic [CNT_W-1:0]   cnt_w [NUM_CNT];
  logic [SEL_W-1:0]   sel_w [NUM_CNT];

  evc_decode #(.NUM_CNT(NUM_CNT)) u_decode (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wr_data_o (wr_data),
    .wr_ctrl_o (wr_ctrl),
    .rd_ok_o   (rd_ok),
    .rd_ctrl_o (rd_ctrl),
    .rd_slot_o (rd_slot)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    evc_counter #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data_i (wr_data[g]),
      .wr_ctrl_i (wr_ctrl[g]),
      .wdata_i   (wdata_i),
      .evt_i     (evt_i),
      .cnt_o     (cnt_w[g]),
      .sel_o     (sel_w[g])
    );
  end

  evc_rdmux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ok_i   (rd_ok),
    .rd_ctrl_i (rd_ctrl),
    .rd_slot_i (rd_slot),
    .cnt_i     (cnt_w),
    .sel_i     (sel_w),
    .rdata_o   (rdata_o)
  );

endmodule

// File: tb/tb_evc_bank.sv
module tb_evc_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [35:0] evt = '0;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  evc_bank dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [7:0]  code;
    logic [35:0] pat;
    logic [7:0]  cyc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'h01, 36'h0_0000_0001, 8'd5},
    '{3'd3, 8'h24, 36'h8_0000_0000, 8'd7},
    '{3'd5, 8'h10, 36'h0_0000_8000, 8'd9},
    '{3'd7, 8'h02, 36'h0_0000_0001, 8'd4},
    '{3'd2, 8'h00, 36'hF_FFFF_FFFF, 8'd6},
    '{3'd6, 8'h30, 36'hF_FFFF_FFFF, 8'd6},
    '{3'd1, 8'h1A, 36'hF_FFFF_FFFF, 8'd3}
  };

  function automatic logic [63:0] expect_count(input logic [7:0] code,
                                               input logic [35:0] pat,
                                               input int cyc);
    if (code == 8'h00 || code > 8'h24) return 64'd0;
    if (((pat >> (code - 8'd1)) & 36'd1) == 36'd0) return 64'd0;
    return 64'(cyc);
  endfunction

  function automatic logic [11:0] data_addr(input int n);
    return 12'(n * 8);
  endfunction

  function automatic logic [11:0] ctrl_addr(input int n);
    return 12'h100 + 12'(n * 8);
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [35:0] pat, input int cyc);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      evt = pat;
    end
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #1 check("R1 rdata in reset", rdata, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register is zero after reset
    for (int n = 0; n < 8; n++) begin
      rd(data_addr(n), v); check("R1 data", v, 64'd0);
      rd(ctrl_addr(n), v); check("R1 ctrl", v, 64'd0);
    end

    // Vector table: R4 counting, R5 idle, R6 high code, R3 readback
    for (int i = 0; i < NV; i++) begin
      wr(data_addr(int'(VEC[i].slot)), 64'd0);
      wr(ctrl_addr(int'(VEC[i].slot)), {56'hABCD_EF01_2345_67, VEC[i].code});
      rd(ctrl_addr(int'(VEC[i].slot)), v);
      check("R3 R6 code readback", v, {56'd0, VEC[i].code});
      pulse(VEC[i].pat, int'(VEC[i].cyc));
      wr(ctrl_addr(int'(VEC[i].slot)), 64'd0);
      pulse(36'hF_FFFF_FFFF, 3);
      rd(data_addr(int'(VEC[i].slot)), v);
      check("R4 R5 R6 count after stop", v,
            expect_count(VEC[i].code, VEC[i].pat, int'(VEC[i].cyc)));
    end

    // R11: every counter still holds its own result
    for (int i = 0; i < NV; i++) begin
      rd(data_addr(int'(VEC[i].slot)), v);
      check("R11 independent counters", v,
            expect_count(VEC[i].code, VEC[i].pat, int'(VEC[i].cyc)));
    end
    rd(data_addr(4), v); check("R11 untouched counter", v, 64'd0);

    // R2: full-width data write and readback
    wr(data_addr(3), 64'h0123_4567_89AB_CDEF);
    rd(data_addr(3), v); check("R2 data readback", v, 64'h0123_4567_89AB_CDEF);

    // R3: upper control bits are dropped
    wr(ctrl_addr(4), 64'hDEAD_BEEF_0000_0105);
    rd(ctrl_addr(4), v); check("R3 upper bits zero", v, 64'h05);
    wr(ctrl_addr(4), 64'd0);

    // R7: write on the same edge as an event wins
    wr(data_addr(0), 64'd0);
    wr(ctrl_addr(0), 64'h01);
    @(negedge clk); evt = 36'h1;
    @(negedge clk); addr = data_addr(0); we = 1'b1; wdata = 64'h100;
    @(negedge clk); we = 1'b0; evt = '0;
    rd(data_addr(0), v); check("R7 write beats increment", v, 64'h100);
    wr(ctrl_addr(0), 64'd0);

    // R8: wrap from all ones
    wr(data_addr(1), 64'hFFFF_FFFF_FFFF_FFFF);
    wr(ctrl_addr(1), 64'h01);
    pulse(36'h1, 1);
    wr(ctrl_addr(1), 64'd0);
    rd(data_addr(1), v); check("R8 wrap to zero", v, 64'd0);

    // R9: registered read shows pre-write state, one cycle late
    rd(data_addr(2), v);
    @(negedge clk); addr = data_addr(2); we = 1'b1; wdata = 64'h55;
    @(posedge clk); #1 check("R9 read before same-edge write", rdata, 64'd0);
    @(negedge clk); we = 1'b0;
    rd(data_addr(2), v); check("R9 new value next read", v, 64'h55);
    @(negedge clk); addr = data_addr(3);
    #1 check("R9 output holds until edge", rdata, 64'h55);
    @(posedge clk); #1 check("R9 output after edge", rdata, 64'h0123_4567_89AB_CDEF);

    // R10: unmapped addresses
    wr(12'h00C, 64'hAAAA);
    wr(12'h040, 64'hBBBB);
    wr(12'h140, 64'h01);
    wr(12'h200, 64'h02);
    wr(12'h104, 64'h03);
    rd(data_addr(1), v); check("R10 misaligned write ignored", v, 64'd0);
    rd(data_addr(0), v); check("R10 index 8 write ignored", v, 64'h100);
    rd(ctrl_addr(0), v); check("R10 ctrl alias ignored", v, 64'd0);
    rd(12'h00C, v); check("R10 misaligned read zero", v, 64'd0);
    rd(12'h200, v); check("R10 region read zero", v, 64'd0);
    rd(12'h140, v); check("R10 index read zero", v, 64'd0);
    pulse(36'hF_FFFF_FFFF, 4);
    rd(data_addr(0), v); check("R10 R5 no stray start", v, 64'h100);

    finish_run();
  end

endmodule